// File: doc/BRIEF.md
# Channel-Indexed Partial Sum Accumulator

This block collects partial-sum rows that a convolution array emits from one-dimensional row convolutions of compressed sparse kernels, and sums them into an on-chip output buffer. Every incoming row is one word per array column (one lane per column). Each row is tagged with the output channel it belongs to and with the output row it feeds. The block turns the channel tag and the row number into a fixed buffer address. It reads the stored partial row, adds the new contribution lane by lane with saturation, and writes the result back. Each lane owns its own memory bank, so the lane number is the element index inside the row.

The upstream scheduler pads its stream with empty rows to keep the kernel layout regular. These rows are accepted and discarded. The first contribution to an output row carries a marker, and that row replaces whatever the buffer held instead of being added to it. Finished rows leave through a read port that shares the bank read path with accumulation. While a read is requested, the input side is held off for that cycle. Two pipeline stages separate a read of the buffer from its write, so a one-entry forwarding register per lane ensures that neither an accumulation nor a read-out ever sees a stale value.

Top module: `psum_accum`

## Requirements
- R1: After a synchronous reset, `rd_valid` is 0 and `in_ready` is 1 while `rd_req` is 0.
- R2: A row tagged with channel c and output row r is stored at bank address c*ROWS_PER_CH + r, in every lane. Rows with different (c, r) pairs never disturb each other.
- R3: An accepted non-empty row with `in_first`=1 replaces the stored row: each lane becomes the sign-extended 16-bit input.
- R4: An accepted non-empty row with `in_first`=0 adds each lane's signed 16-bit input to the stored 24-bit value of the same lane.
- R5: Sums saturate to the 24-bit signed range, +8388607 at the top and -8388608 at the bottom.
- R6: An accepted row with `in_empty`=1 causes no buffer write, whatever its `in_first` and data.
- R7: Rows for the same address accepted on consecutive cycles accumulate exactly as if they had been spaced apart.
- R8: `rd_req`=1 in cycle t gives `rd_valid`=1 in cycle t+2. `rd_data` (lane i at bits [24*i+23:24*i]) then holds every row accepted before cycle t, including a row still in flight.
- R9: `in_ready` is 0 in any cycle with `rd_req`=1, and an input offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Partial-sum row offered |
| in_ready | output | 1 | Row can be taken this cycle |
| in_fid | input | FID_W | Output-channel tag of the row |
| in_row | input | ROW_W | Output row within the channel |
| in_first | input | 1 | First contribution: overwrite instead of add |
| in_empty | input | 1 | Padding row, no write |
| in_data | input | LANES*IN_W | Signed lane inputs, lane i at bits [IN_W*i+IN_W-1:IN_W*i] |
| rd_req | input | 1 | Read one accumulated row |
| rd_fid | input | FID_W | Channel to read |
| rd_row | input | ROW_W | Row to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | LANES*ACC_W | Accumulated row, lane i at bits [ACC_W*i+ACC_W-1:ACC_W*i] |

## Verification
Accumulation and read-out can meet on one bank address within a cycle. The buffer write of an accumulated row lands on the same clock edge at which a read of that address is issued, and only the forwarding register can supply the new value. The bench provokes this by issuing a read on the cycle right after a row for the same channel and row is accepted. It also feeds back-to-back rows to a few addresses at random, mixed with reads. Every read-out is compared lane by lane with a bench model that applies overwrite, add and saturation in the order the rows were accepted.

// File: rtl/psum_pkg.sv
package psum_pkg;
  // Default geometry: one lane per array column.
  localparam int unsigned DEF_LANES       = 12;
  localparam int unsigned DEF_IN_W        = 16;
  localparam int unsigned DEF_ACC_W       = 24;
  localparam int unsigned DEF_NUM_CH      = 16;
  localparam int unsigned DEF_ROWS_PER_CH = 8;

  // Kind of work occupying the second pipeline stage.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_READ = 2'd2
  } stage_op_e;
endpackage

// File: rtl/psum_addr_gen.sv
module psum_addr_gen #(
  parameter int unsigned NUM_CH      = 16,
  parameter int unsigned ROWS_PER_CH = 8,
  localparam int unsigned FID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ROW_W  = (ROWS_PER_CH > 1) ? $clog2(ROWS_PER_CH) : 1,
  localparam int unsigned DEPTH  = NUM_CH * ROWS_PER_CH,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [FID_W-1:0]  fid,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  // Each channel owns a fixed block of ROWS_PER_CH words.
  assign addr = ADDR_W'(fid) * ADDR_W'(ROWS_PER_CH) + ADDR_W'(row);
endmodule

// File: rtl/psum_bank.sv
module psum_bank #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  // Simple dual-port, read-first block memory.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/psum_lane.sv
module psum_lane #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              s1_we,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic              s1_first,
  input  logic [IN_W-1:0]   s1_din,
  output logic [ACC_W-1:0]  cur_val
);
  localparam logic [ACC_W:0] POS_MAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W:0] NEG_MIN = {2'b11, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] bank_q;
  logic             lw_valid;
  logic [ADDR_W-1:0] lw_addr;
  logic [ACC_W-1:0] lw_data;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   wide_sum;
  logic [ACC_W-1:0] sat_sum;

  psum_bank #(.DATA_W(ACC_W), .DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .re    (re),
    .raddr (raddr),
    .rdata (bank_q),
    .we    (s1_we),
    .waddr (s1_addr),
    .wdata (sat_sum)
  );

  // The previous write lands on the edge that issued this read; bypass it.
  always_comb begin
    if (lw_valid && (lw_addr == s1_addr)) cur_val = lw_data;
    else                                  cur_val = bank_q;
  end

  always_comb begin
    base     = s1_first ? '0 : cur_val;
    wide_sum = {base[ACC_W-1], base} +
               {{(ACC_W+1-IN_W){s1_din[IN_W-1]}}, s1_din};
    if (wide_sum[ACC_W] != wide_sum[ACC_W-1])
      sat_sum = wide_sum[ACC_W] ? NEG_MIN[ACC_W-1:0] : POS_MAX[ACC_W-1:0];
    else
      sat_sum = wide_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) lw_valid <= 1'b0;
    else     lw_valid <= s1_we;
    lw_addr <= s1_addr;
    lw_data <= sat_sum;
  end
endmodule

// File: rtl/psum_accum.sv
module psum_accum
  import psum_pkg::*;
#(
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned IN_W        = DEF_IN_W,
  parameter int unsigned ACC_W       = DEF_ACC_W,
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned ROWS_PER_CH = DEF_ROWS_PER_CH,
  localparam int unsigned FID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ROW_W  = (ROWS_PER_CH > 1) ? $clog2(ROWS_PER_CH) : 1,
  localparam int unsigned DEPTH  = NUM_CH * ROWS_PER_CH,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [FID_W-1:0]       in_fid,
  input  logic [ROW_W-1:0]       in_row,
  input  logic                   in_first,
  input  logic                   in_empty,
  input  logic [LANES*IN_W-1:0]  in_data,
  input  logic                   rd_req,
  input  logic [FID_W-1:0]       rd_fid,
  input  logic [ROW_W-1:0]       rd_row,
  output logic                   rd_valid,
  output logic [LANES*ACC_W-1:0] rd_data
);
  logic [ADDR_W-1:0]     acc_addr;
  logic [ADDR_W-1:0]     rdq_addr;
  logic [ADDR_W-1:0]     bank_raddr;
  logic                  bank_re;
  logic                  acc_fire;
  logic                  acc_live;
  stage_op_e             s1_op;
  logic [ADDR_W-1:0]     s1_addr;
  logic                  s1_first;
  logic [LANES*IN_W-1:0] s1_data;
  logic                  s1_we;
  logic [LANES*ACC_W-1:0] row_now;

  psum_addr_gen #(.NUM_CH(NUM_CH), .ROWS_PER_CH(ROWS_PER_CH)) u_acc_addr (
    .fid (in_fid), .row (in_row), .addr (acc_addr)
  );

  psum_addr_gen #(.NUM_CH(NUM_CH), .ROWS_PER_CH(ROWS_PER_CH)) u_rd_addr (
    .fid (rd_fid), .row (rd_row), .addr (rdq_addr)
  );

  // Read-out owns the bank read port in its cycle; accumulation waits.
  assign in_ready   = !rst && !rd_req;
  assign acc_fire   = in_valid && in_ready;
  assign acc_live   = acc_fire && !in_empty;
  assign bank_raddr = rd_req ? rdq_addr : acc_addr;
  assign bank_re    = rd_req || acc_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= ST_IDLE;
    end else if (rd_req) begin
      s1_op <= ST_READ;
    end else if (acc_live) begin
      s1_op <= ST_ACC;
    end else begin
      s1_op <= ST_IDLE;
    end
    s1_addr  <= bank_raddr;
    s1_first <= in_first;
    s1_data  <= in_data;
  end

  assign s1_we = (s1_op == ST_ACC);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psum_lane #(.IN_W(IN_W), .ACC_W(ACC_W), .DEPTH(DEPTH)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .re       (bank_re),
      .raddr    (bank_raddr),
      .s1_we    (s1_we),
      .s1_addr  (s1_addr),
      .s1_first (s1_first),
      .s1_din   (s1_data[g*IN_W +: IN_W]),
      .cur_val  (row_now[g*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= (s1_op == ST_READ);
    if (s1_op == ST_READ) rd_data <= row_now;
  end
endmodule

// File: rtl/psum_accum_chk.sv
module psum_accum_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_empty,
  input logic rd_req,
  input logic rd_valid,
  input logic s1_we
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rd_valid);

  assert_live_row_writes_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_empty) |=> s1_we);

  assert_empty_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_empty) |=> !s1_we);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 rd_valid);

  assert_read_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !in_ready);
endmodule

bind psum_accum psum_accum_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_empty (in_empty),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .s1_we    (s1_we)
);

// File: tb/sim_psum_accum.sv
`timescale 1ns/1ps
module sim_psum_accum;
  localparam int LANES = 12;
  localparam int IN_W  = 16;
  localparam int ACC_W = 24;
  localparam int NCH   = 16;
  localparam int NROW  = 8;
  localparam int PMAX  = 8388607;
  localparam int NMIN  = -8388608;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_fid = '0;
  logic [2:0] in_row = '0;
  logic in_first = 1'b0;
  logic in_empty = 1'b0;
  logic [LANES*IN_W-1:0] in_data = '0;
  logic rd_req = 1'b0;
  logic [3:0] rd_fid = '0;
  logic [2:0] rd_row = '0;
  logic rd_valid;
  logic [LANES*ACC_W-1:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int model [NCH][NROW][LANES];
  bit seen [NCH][NROW];
  int lane_v [LANES];

  always #2.5 clk = ~clk;

  psum_accum u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fid(in_fid), .in_row(in_row), .in_first(in_first), .in_empty(in_empty),
    .in_data(in_data), .rd_req(rd_req), .rd_fid(rd_fid), .rd_row(rd_row),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int clamp(input int v);
    if (v > PMAX) return PMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  function automatic int rnd16();
    return int'($urandom % 65536) - 32768;
  endfunction

  // Offer one row for a single cycle and update the model if it is live.
  task automatic push(input int f, input int r, input bit first, input bit empty);
    in_fid = 4'(f); in_row = 3'(r); in_first = first; in_empty = empty;
    for (int l = 0; l < LANES; l++) in_data[l*IN_W +: IN_W] = lane_v[l][15:0];
    in_valid = 1'b1;
    if (!empty) begin
      for (int l = 0; l < LANES; l++)
        model[f][r][l] = clamp((first ? 0 : model[f][r][l]) + lane_v[l]);
      seen[f][r] = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_empty = 1'b0;
  endtask

  task automatic set_all(input int v);
    for (int l = 0; l < LANES; l++) lane_v[l] = v;
  endtask

  task automatic read_check(input int f, input int r, input string tag);
    bit bad;
    rd_fid = 4'(f); rd_row = 3'(r); rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    tests++;
    bad = 1'b0;
    if (!rd_valid) begin
      bad = 1'b1;
      $display("FAIL %s rd_valid got %0b expected 1", tag, rd_valid);
    end else begin
      for (int l = 0; l < LANES; l++) begin
        int got;
        got = int'($signed(rd_data[l*ACC_W +: ACC_W]));
        if (!bad && got != model[f][r][l]) begin
          bad = 1'b1;
          $display("FAIL %s ch%0d row%0d lane%0d got %0d expected %0d",
                   tag, f, r, l, got, model[f][r][l]);
        end
      end
    end
    if (bad) fails++;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: idle state after reset
    tests++;
    if (rd_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 rd_valid/in_ready got %b%b expected 01", rd_valid, in_ready);
    end

    // R3: first row overwrites; R4: later rows add per lane
    for (int l = 0; l < LANES; l++) lane_v[l] = 100 * l - 300;
    push(2, 5, 1'b1, 1'b0);
    read_check(2, 5, "R3 first overwrite");
    for (int l = 0; l < LANES; l++) lane_v[l] = -7 * l + 1;
    push(2, 5, 1'b0, 1'b0);
    read_check(2, 5, "R4 add per lane");
    set_all(55);
    push(2, 5, 1'b1, 1'b0);
    read_check(2, 5, "R3 re-first drops old sum");

    // R2: neighbouring channels and rows stay separate
    set_all(11);   push(0, 7, 1'b1, 1'b0);
    set_all(-22);  push(1, 0, 1'b1, 1'b0);
    set_all(33);   push(15, 7, 1'b1, 1'b0);
    set_all(44);   push(0, 6, 1'b1, 1'b0);
    read_check(0, 7, "R2 ch0 row7");
    read_check(1, 0, "R2 ch1 row0");
    read_check(15, 7, "R2 ch15 row7");
    read_check(0, 6, "R2 ch0 row6");

    // R6: padding rows never write, even flagged first
    for (int l = 0; l < LANES; l++) lane_v[l] = 999 + l;
    push(1, 0, 1'b1, 1'b1);
    push(1, 0, 1'b0, 1'b1);
    read_check(1, 0, "R6 empty row ignored");

    // R7: back-to-back rows on one address
    set_all(1000); push(3, 3, 1'b1, 1'b0);
    set_all(-250); push(3, 3, 1'b0, 1'b0);
    set_all(17);   push(3, 3, 1'b0, 1'b0);
    set_all(5);    push(3, 2, 1'b0, 1'b1);
    set_all(-4);   push(3, 3, 1'b0, 1'b0);
    read_check(3, 3, "R7 back-to-back");

    // R8: read issued while the last row for that address is being written
    set_all(321);  push(4, 1, 1'b1, 1'b0);
    read_check(4, 1, "R8 read meets write");
    set_all(-9);   push(4, 1, 1'b0, 1'b0);
    read_check(4, 1, "R8 read meets second write");

    // R9: input offered together with a read is refused
    set_all(12345);
    in_fid = 4'd4; in_row = 3'd1; in_first = 1'b1; in_empty = 1'b0;
    for (int l = 0; l < LANES; l++) in_data[l*IN_W +: IN_W] = lane_v[l][15:0];
    in_valid = 1'b1;
    rd_fid = 4'd0; rd_row = 3'd7; rd_req = 1'b1;
    #1;
    tests++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R9 in_ready got %b expected 0", in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    read_check(4, 1, "R9 refused row not stored");

    // R5: saturation at both ends
    set_all(32767);
    push(6, 0, 1'b1, 1'b0);
    repeat (259) push(6, 0, 1'b0, 1'b0);
    read_check(6, 0, "R5 positive clamp");
    set_all(-32768);
    repeat (520) push(6, 0, 1'b0, 1'b0);
    read_check(6, 0, "R5 negative clamp");
    set_all(1);
    push(6, 0, 1'b0, 1'b0);
    read_check(6, 0, "R5 leaves floor");

    // Random mix on a few addresses to provoke hazards (R4, R6, R7, R8)
    for (int n = 0; n < 600; n++) begin
      int f, r;
      f = int'($urandom % 3) + 8;
      r = int'($urandom % 2);
      if (seen[f][r] && ($urandom % 4 == 0)) begin
        read_check(f, r, "R8 random read");
      end else begin
        bit first, empty;
        first = !seen[f][r] || ($urandom % 8 == 0);
        empty = ($urandom % 6 == 0);
        for (int l = 0; l < LANES; l++) lane_v[l] = rnd16();
        push(f, r, first, empty);
      end
    end
    for (int f = 8; f < 11; f++)
      for (int r = 0; r < 2; r++)
        if (seen[f][r]) read_check(f, r, "R7 random final");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule